// File: doc/BRIEF.md
# Host-to-DSP Word Mailbox with Selectable Handshake

This block is a pair of one-word mailboxes between an 8-bit host bus and a DSP core. The host fills an inbound word register that the DSP drains. The DSP fills an outbound word register that the host drains. Every 16-bit word crosses the host bus as two byte transfers, high byte first. A word counts as moved only when its second byte completes. A status register on the host side reports inbound-empty and outbound-full, and it holds two interrupt enable bits.

The host can synchronise in one of three ways, chosen by a static mode input that is captured while reset is asserted:
- **Acknowledge mode:** a write to a full inbound register is stalled until the DSP takes the word.
- **Polling mode:** every access is acknowledged after a fixed latency, and the host watches the status flags.
- **Interrupt mode:** two active-low requests are raised from the flags and ANDed onto one interrupt line.

On the DSP side, a read strobe frees the inbound register. A write strobe loads the outbound register when it is empty.

Top module: `hostdsp_mailbox`

## Requirements
- R1: After reset the status register reads 0x01 (bit0 inbound-empty = 1, bit1 outbound-full = 0, bit2 inbound-interrupt enable = 0, bit3 outbound-interrupt enable = 0, bits 7:4 = 0). All three interrupt outputs are high and `dsp_in_full` and `dsp_out_full` are low.
- R2: Host writes to address 0 carry the inbound word, high byte first. `dsp_in_full` rises only after the second byte, and `dsp_in_data` then holds {first byte, second byte}.
- R3: A one-cycle `dsp_rd` pulse clears `dsp_in_full`, and status bit0 reads 1 again.
- R4: When `dsp_out_full` is low, `dsp_wr` loads `dsp_wdata` and sets `dsp_out_full`. Host reads of address 1 return the high byte and then the low byte. `dsp_out_full` clears only after the second read. A `dsp_wr` while the outbound register is full is ignored.
- R5: Except for a stalled write, each access (chip select held high) gets a one-cycle `host_ack` pulse on the ACK_LAT-th rising clock edge after the select is first seen. Read data is valid together with the acknowledge.
- R6: In acknowledge mode (mode 2'b00), a first-byte write to address 0 while the inbound register is full is held without acknowledge until `dsp_rd`. It then completes one edge after the register is freed, and its byte is kept.
- R7: In polling mode (mode 2'b01), a write to a full inbound register is acknowledged and discarded. A read of address 1 while the outbound register is empty returns 0 and does not advance the byte order.
- R8: A host write to address 2 sets the inbound-interrupt enable from data bit 2 and the outbound-interrupt enable from data bit 3. Both enables read back in the same bit positions.
- R9: In interrupt mode (mode 2'b10), `in_irq_n` is low while its enable is set, the inbound register is empty and no high byte is waiting. `out_irq_n` is low while its enable is set, the outbound register is full and no byte has been read yet. Each request rises after the first byte transfer. `host_irq_n` is low when either request is low.
- R10: In acknowledge and polling modes, all interrupt outputs stay high whatever the enables and flags.
- R11: The mode is taken from `mode_sel` only while `rst_n` is low. Changing `mode_sel` after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; mode captured while low |
| mode_sel | input | 2 | Handshake mode: 00 acknowledge, 01 polling, 10 interrupt, 11 polling |
| host_cs | input | 1 | Access request, held high until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 inbound word, 1 outbound word, 2 status/enables |
| host_wdata | input | BYTE_W | Host write byte |
| host_rdata | output | BYTE_W | Host read byte, valid with acknowledge |
| host_ack | output | 1 | One-cycle access acknowledge |
| in_irq_n | output | 1 | Inbound request, active low |
| out_irq_n | output | 1 | Outbound request, active low |
| host_irq_n | output | 1 | Combined host-port interrupt, active low |
| dsp_in_data | output | 2*BYTE_W | Inbound word for the DSP |
| dsp_in_full | output | 1 | Inbound word waiting for the DSP |
| dsp_rd | input | 1 | DSP has taken the inbound word |
| dsp_wdata | input | 2*BYTE_W | Outbound word from the DSP |
| dsp_wr | input | 1 | Load outbound word |
| dsp_out_full | output | 1 | Outbound word not yet fully read by host |

## Verification
The bench measures acknowledge latency in edges. A design that stalled in the wrong mode, or never released the stall, shows a wrong count or hangs until the watchdog fires. The stalled write is released by a `dsp_rd` at a known cycle, and the released byte must land in the new word. A design that dropped or duplicated it would show a wrong `dsp_in_data`. The interrupt lines are sampled between the two byte transfers, where a request that ignored the byte phase would still be low. Writes to a full register, reads of an empty one, and a DSP write to a full outbound register are followed by reads that expose any corruption of order or data.

// File: rtl/hostdsp_mailbox.sv
module hostdsp_mailbox #(
  parameter int BYTE_W  = 8,
  parameter int ACK_LAT = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_ack,
  output logic              in_irq_n,
  output logic              out_irq_n,
  output logic              host_irq_n,
  output logic [WORD_W-1:0] dsp_in_data,
  output logic              dsp_in_full,
  input  logic              dsp_rd,
  input  logic [WORD_W-1:0] dsp_wdata,
  input  logic              dsp_wr,
  output logic              dsp_out_full
);
  localparam int CW = $clog2(ACK_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_LAT - 1);
  localparam logic [1:0] M_ACK = 2'b00;
  localparam logic [1:0] M_IRQ = 2'b10;

  logic [1:0]        mode_q;
  logic [CW-1:0]     cnt;
  logic              done_q;
  logic              in_full, in_phase, out_full, out_phase;
  logic              in_en, out_en;
  logic [BYTE_W-1:0] hold;
  logic [WORD_W-1:0] in_data, out_data;
  logic              pending, stall, fire, in_take, rd_out;
  logic [BYTE_W-1:0] status;

  assign pending = host_cs & ~done_q;
  assign stall   = (mode_q == M_ACK) & host_we & (host_addr == 2'd0) & in_full & ~in_phase;
  assign fire    = pending & (cnt == LAST) & ~stall;
  assign in_take = fire & host_we & (host_addr == 2'd0) & (in_phase | ~in_full);
  assign rd_out  = fire & ~host_we & (host_addr == 2'd1) & out_full;
  assign status  = {{(BYTE_W-4){1'b0}}, out_en, in_en, out_full, ~in_full};

  assign in_irq_n   = ~((mode_q == M_IRQ) & in_en & ~in_full & ~in_phase);
  assign out_irq_n  = ~((mode_q == M_IRQ) & out_en & out_full & ~out_phase);
  assign host_irq_n = in_irq_n & out_irq_n;

  assign dsp_in_data  = in_data;
  assign dsp_in_full  = in_full;
  assign dsp_out_full = out_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= mode_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      done_q   <= 1'b0;
      host_ack <= 1'b0;
    end else begin
      host_ack <= fire;
      if (!pending) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      if (!host_cs) done_q <= 1'b0;
      else if (fire) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full  <= 1'b0;
      in_phase <= 1'b0;
      hold     <= '0;
      in_data  <= '0;
    end else begin
      if (dsp_rd) in_full <= 1'b0;
      if (in_take) begin
        if (!in_phase) begin
          hold     <= host_wdata;
          in_phase <= 1'b1;
        end else begin
          in_data  <= {hold, host_wdata};
          in_full  <= 1'b1;
          in_phase <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_full  <= 1'b0;
      out_phase <= 1'b0;
      out_data  <= '0;
    end else begin
      if (dsp_wr && !out_full) begin
        out_data <= dsp_wdata;
        out_full <= 1'b1;
      end
      if (rd_out) begin
        out_phase <= ~out_phase;
        if (out_phase) out_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en      <= 1'b0;
      out_en     <= 1'b0;
      host_rdata <= '0;
    end else if (fire) begin
      if (host_we && host_addr == 2'd2) begin
        in_en  <= host_wdata[2];
        out_en <= host_wdata[3];
      end
      if (!host_we) begin
        case (host_addr)
          2'd1:    host_rdata <= rd_out ? (out_phase ? out_data[BYTE_W-1:0]
                                                     : out_data[WORD_W-1:BYTE_W])
                                        : '0;
          2'd2:    host_rdata <= status;
          default: host_rdata <= '0;
        endcase
      end
    end
  end

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && stall) |=> !host_ack);

  // R2
  word_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_full) |-> $past(in_phase));

  // R4
  word_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_full) |-> $past(out_phase));

  // R4
  out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && out_full) |=> $stable(out_data));

  // R10
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq_n |-> (mode_q == M_IRQ));
endmodule

// File: tb/hostdsp_mailbox_bench.sv
module hostdsp_mailbox_bench;
  localparam int BW  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          host_cs = 1'b0, host_we = 1'b0;
  logic [1:0]    host_addr = '0;
  logic [BW-1:0] host_wdata = '0;
  logic [BW-1:0] host_rdata;
  logic          host_ack, in_irq_n, out_irq_n, host_irq_n;
  logic [2*BW-1:0] dsp_in_data, dsp_wdata = '0;
  logic          dsp_in_full, dsp_rd = 1'b0, dsp_wr = 1'b0, dsp_out_full;

  int checks = 0, fails = 0;
  bit done = 0;

  hostdsp_mailbox #(.BYTE_W(BW), .ACK_LAT(LAT)) u_hostdsp_mailbox (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 0; mode_sel = m;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic access(input bit we, input logic [1:0] a, input logic [BW-1:0] d,
                        output logic [BW-1:0] rd, output int lat);
    @(negedge clk);
    host_cs = 1; host_we = we; host_addr = a; host_wdata = d; lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!host_ack && lat < 1000);
    rd = host_rdata;
    host_cs = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); dsp_rd = 1;
    @(negedge clk); dsp_rd = 0;
  endtask

  task automatic pulse_wr(input logic [2*BW-1:0] w);
    @(negedge clk); dsp_wr = 1; dsp_wdata = w;
    @(negedge clk); dsp_wr = 0;
  endtask

  task automatic t_reset();
    logic [BW-1:0] r; int l;
    do_reset(2'b10);
    access(0, 2'd2, 0, r, l);
    chk(r == 8'h01, "R1 status", r, 8'h01);
    chk({in_irq_n, out_irq_n, host_irq_n} == 3'b111, "R1 irq", {in_irq_n, out_irq_n, host_irq_n}, 7);
    chk(!dsp_in_full && !dsp_out_full, "R1 dsp flags", {dsp_in_full, dsp_out_full}, 0);
    chk(l == LAT, "R5 latency", l, LAT);
  endtask

  task automatic t_inbound();
    logic [BW-1:0] r; int l;
    do_reset(2'b01);
    access(1, 2'd0, 8'hA5, r, l);
    chk(!dsp_in_full, "R2 not full after first byte", dsp_in_full, 0);
    access(1, 2'd0, 8'h3C, r, l);
    chk(dsp_in_full, "R2 full after second byte", dsp_in_full, 1);
    chk(dsp_in_data == 16'hA53C, "R2 word", dsp_in_data, 16'hA53C);
    access(0, 2'd2, 0, r, l);
    chk(r[0] == 0, "R2 status empty bit", r[0], 0);
    pulse_rd();
    chk(!dsp_in_full, "R3 cleared", dsp_in_full, 0);
    access(0, 2'd2, 0, r, l);
    chk(r[0] == 1, "R3 status empty bit", r[0], 1);
  endtask

  task automatic t_outbound();
    logic [BW-1:0] r; int l;
    do_reset(2'b01);
    pulse_wr(16'h1234);
    chk(dsp_out_full, "R4 full", dsp_out_full, 1);
    pulse_wr(16'hFFFF);
    access(0, 2'd1, 0, r, l);
    chk(r == 8'h12, "R4 high byte, ignored dsp_wr", r, 8'h12);
    chk(dsp_out_full, "R4 full mid-word", dsp_out_full, 1);
    access(0, 2'd1, 0, r, l);
    chk(r == 8'h34, "R4 low byte", r, 8'h34);
    chk(!dsp_out_full, "R4 cleared", dsp_out_full, 0);
    access(0, 2'd1, 0, r, l);
    chk(r == 0, "R7 empty read data", r, 0);
    pulse_wr(16'h5678);
    access(0, 2'd1, 0, r, l);
    chk(r == 8'h56, "R7 order not advanced", r, 8'h56);
    access(0, 2'd1, 0, r, l);
  endtask

  task automatic t_poll_drop();
    logic [BW-1:0] r; int l;
    do_reset(2'b01);
    access(1, 2'd0, 8'h11, r, l);
    access(1, 2'd0, 8'h22, r, l);
    access(1, 2'd0, 8'h99, r, l);
    chk(l == LAT, "R7 write to full acknowledged", l, LAT);
    pulse_rd();
    access(1, 2'd0, 8'h33, r, l);
    access(1, 2'd0, 8'h44, r, l);
    chk(dsp_in_data == 16'h3344, "R7 dropped write", dsp_in_data, 16'h3344);
  endtask

  task automatic t_ack_stall();
    logic [BW-1:0] r; int l;
    do_reset(2'b00);
    access(1, 2'd0, 8'hDE, r, l);
    access(1, 2'd0, 8'hAD, r, l);
    @(negedge clk);
    fork
      access(1, 2'd0, 8'hBE, r, l);
      begin
        repeat (10) @(negedge clk);
        dsp_rd = 1;
        @(negedge clk);
        dsp_rd = 0;
      end
    join
    chk(l == 11, "R6 stall length", l, 11);
    access(1, 2'd0, 8'hEF, r, l);
    chk(l == LAT, "R5 latency after stall", l, LAT);
    chk(dsp_in_full && dsp_in_data == 16'hBEEF, "R6 kept byte", dsp_in_data, 16'hBEEF);
  endtask

  task automatic t_enables_quiet();
    logic [BW-1:0] r; int l;
    do_reset(2'b00);
    access(1, 2'd2, 8'h0C, r, l);
    access(0, 2'd2, 0, r, l);
    chk(r == 8'h0D, "R8 enables readback", r, 8'h0D);
    pulse_wr(16'h0001);
    chk(host_irq_n && in_irq_n && out_irq_n, "R10 ack mode quiet", host_irq_n, 1);
    do_reset(2'b01);
    access(1, 2'd2, 8'h0C, r, l);
    pulse_wr(16'h0001);
    chk(host_irq_n && in_irq_n && out_irq_n, "R10 poll mode quiet", host_irq_n, 1);
  endtask

  task automatic t_irq();
    logic [BW-1:0] r; int l;
    do_reset(2'b10);
    mode_sel = 2'b00;
    access(1, 2'd2, 8'h04, r, l);
    chk(!in_irq_n && !host_irq_n, "R11 irq mode kept / R9 in request", in_irq_n, 0);
    chk(out_irq_n, "R9 out idle", out_irq_n, 1);
    access(1, 2'd0, 8'h01, r, l);
    chk(in_irq_n && host_irq_n, "R9 in drops after first byte", in_irq_n, 1);
    access(1, 2'd0, 8'h02, r, l);
    chk(in_irq_n, "R9 in off while full", in_irq_n, 1);
    pulse_rd();
    chk(!in_irq_n, "R9 in returns", in_irq_n, 0);
    access(1, 2'd2, 8'h08, r, l);
    chk(in_irq_n && host_irq_n, "R8 in enable off", in_irq_n, 1);
    pulse_wr(16'hCAFE);
    chk(!out_irq_n && !host_irq_n, "R9 out request", out_irq_n, 0);
    access(0, 2'd1, 0, r, l);
    chk(out_irq_n && host_irq_n, "R9 out drops after first byte", out_irq_n, 1);
    access(0, 2'd1, 0, r, l);
    chk(r == 8'hFE && out_irq_n, "R9 out after second byte", r, 8'hFE);
    pulse_wr(16'hBEEF);
    chk(!out_irq_n, "R9 out new request", out_irq_n, 0);
  endtask

  initial begin
    t_reset();
    t_inbound();
    t_outbound();
    t_poll_drop();
    t_ack_stall();
    t_enables_quiet();
    t_irq();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end
endmodule